// File: doc/BRIEF.md
# Serial Link Reset and Wake Controller

This block sits on the codec side of a serial audio link. It decides whether the link is running, powered down, or coming back up. It runs from a free-running local reference clock because the link bit clock is stopped whenever the link is down. Its inputs are an asynchronous active-low cold reset, the frame sync line, and two power-down control bits taken from the register file. One bit is a plain link power-down. The other is a deeper power-down.

A cold reset puts the register file back to its defaults. Once the cold reset is released, the bit clock is enabled again. While the link is stopped, a warm wake-up restarts it without touching any register. The block recognises a warm wake-up by timing a high pulse on the sync line against a minimum width, counted in reference-clock cycles. After the pulse ends, the bit clock is held off for a guard interval before it starts again. If the deeper power-down bit was set, sync pulses are ignored and only a cold reset brings the link back.

The sync input passes through a two-stage synchronizer. Every timing figure below counts rising edges of `clk`, with edge 0 being the first edge after the input changed.

Top module: `link_wake_ctrl`

## Requirements
- R1: While `rst_n_cold` is low, the block is held in the reset state without waiting for a clock edge. In that state `link_state` = 0, `regs_rst` = 1 and `bclk_en` = 0.
- R2: On the first clock edge after `rst_n_cold` is released, the block enters the running state. In that state `link_state` = 1, `bclk_en` = 1 and `regs_rst` = 0.
- R3: While running, a high level on `pd_link` or `pd_deep` moves the block to the stopped state on the next edge. In that state `link_state` = 2 and `bclk_en` = 0.
- R4: When stopped with the deep bit not latched, a `sync_in` high pulse of at least `SYNC_MIN_CYC` cycles starts a warm wake-up. The block enters the restart-wait state (`link_state` = 3) on the third edge after `sync_in` falls.
- R5: When stopped, a `sync_in` high pulse shorter than `SYNC_MIN_CYC` cycles is ignored, and the block stays in the stopped state.
- R6: The restart-wait state lasts exactly `RESTART_CYC` cycles with `bclk_en` = 0. The block then returns to the running state with `bclk_en` = 1.
- R7: If `pd_deep` is high when the block enters the stopped state, or at any time while it is stopped, the deep bit is latched. From then on, sync pulses of any width are ignored and only a cold reset leaves the stopped state.
- R8: While running with both power-down bits low, any activity on `sync_in` has no effect on `link_state`.
- R9: `regs_rst` is high only in the reset state. It stays low through power-down, the warm wake-up and the restart wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local reference clock |
| rst_n_cold | input | 1 | Asynchronous active-low cold reset |
| sync_in | input | 1 | Frame sync line from the link controller (asynchronous) |
| pd_link | input | 1 | Link power-down request bit |
| pd_deep | input | 1 | Deep power-down bit; only a cold reset can wake the link |
| bclk_en | output | 1 | Enable for the link bit clock and serial data output |
| regs_rst | output | 1 | Reset to the register file, high while in the reset state |
| link_state | output | 2 | 0 reset, 1 running, 2 stopped, 3 restart wait |

## Verification
Sync pulses are drawn at random around the minimum width, including exactly one cycle below and exactly at the threshold. This separates accepted wake-ups from rejected ones, and a function in the bench predicts each outcome from the pulse width and the latched deep bit. Every cycle of each restart wait is compared against the guard length, so that an early clock start is caught. Power-down is entered through the plain bit alone, through the deep bit, and through the plain bit with the deep bit raised later. The last case tells whether the latch follows the deep bit while the block is stopped. Random sync toggling while running, and `regs_rst` sampled throughout each wake-up, show that neither the running state nor the registers are disturbed.

// File: rtl/link_wake_ctrl.sv
module link_wake_ctrl #(
  parameter int SYNC_MIN_CYC = 100,
  parameter int RESTART_CYC  = 20
) (
  input  logic       clk,
  input  logic       rst_n_cold,
  input  logic       sync_in,
  input  logic       pd_link,
  input  logic       pd_deep,
  output logic       bclk_en,
  output logic       regs_rst,
  output logic [1:0] link_state
);
  localparam int HW = $clog2(SYNC_MIN_CYC + 1);
  localparam int WW = $clog2(RESTART_CYC + 1);

  typedef enum logic [1:0] {
    ST_RESET  = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DOWN   = 2'd2,
    ST_WAIT   = 2'd3
  } st_t;

  st_t st, st_nx;
  logic s1, s2, s_d;
  logic [HW-1:0] hi_cnt;
  logic [WW-1:0] w_cnt;
  logic deep_q;

  wire sync_fall = s_d & ~s2;
  wire pulse_ok  = hi_cnt >= HW'(SYNC_MIN_CYC);
  wire wait_done = w_cnt == WW'(RESTART_CYC - 1);

  always_ff @(posedge clk or negedge rst_n_cold)
    if (!rst_n_cold) {s1, s2, s_d} <= 3'b000;
    else             {s1, s2, s_d} <= {sync_in, s1, s2};

  always_comb begin
    st_nx = st;
    case (st)
      ST_RESET:  st_nx = ST_ACTIVE;
      ST_ACTIVE: if (pd_link | pd_deep) st_nx = ST_DOWN;
      ST_DOWN:   if (sync_fall && pulse_ok && !deep_q && !pd_deep) st_nx = ST_WAIT;
      ST_WAIT:   if (wait_done) st_nx = ST_ACTIVE;
      default:   st_nx = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_cold)
    if (!rst_n_cold) st <= ST_RESET;
    else             st <= st_nx;

  always_ff @(posedge clk or negedge rst_n_cold)
    if (!rst_n_cold)                         deep_q <= 1'b0;
    else if (st == ST_ACTIVE)                deep_q <= pd_deep;
    else if (st == ST_DOWN)                  deep_q <= deep_q | pd_deep;
    else                                     deep_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n_cold)
    if (!rst_n_cold)                         hi_cnt <= '0;
    else if (st == ST_DOWN && s2) begin
      if (!pulse_ok)                         hi_cnt <= hi_cnt + 1'b1;
    end else                                 hi_cnt <= '0;

  always_ff @(posedge clk or negedge rst_n_cold)
    if (!rst_n_cold)       w_cnt <= '0;
    else if (st == ST_WAIT) w_cnt <= w_cnt + 1'b1;
    else                   w_cnt <= '0;

  assign bclk_en    = (st == ST_ACTIVE);
  assign regs_rst   = (st == ST_RESET);
  assign link_state = st;

  a_r9_no_return_to_reset: assert property (@(posedge clk) disable iff (!rst_n_cold)
    (st != ST_RESET) |=> (st != ST_RESET));
  a_r4_wait_only_from_down: assert property (@(posedge clk) disable iff (!rst_n_cold)
    $rose(st == ST_WAIT) |-> ($past(st) == ST_DOWN));
  a_r6_guard_held: assert property (@(posedge clk) disable iff (!rst_n_cold)
    (st == ST_WAIT && !wait_done) |=> (st == ST_WAIT && !bclk_en));
  a_r5_short_pulse_ignored: assert property (@(posedge clk) disable iff (!rst_n_cold)
    (st == ST_DOWN && sync_fall && !pulse_ok) |=> (st == ST_DOWN));
  a_r7_deep_holds: assert property (@(posedge clk) disable iff (!rst_n_cold)
    (st == ST_DOWN && deep_q) |=> (st == ST_DOWN));
  a_r8_active_stable: assert property (@(posedge clk) disable iff (!rst_n_cold)
    (st == ST_ACTIVE && !pd_link && !pd_deep) |=> (st == ST_ACTIVE));
endmodule

// File: tb/sim_link_wake_ctrl.sv
`timescale 1ns/1ps
module sim_link_wake_ctrl;
  localparam int MINW = 100;
  localparam int RC   = 20;

  logic clk = 1'b0;
  logic rst_n_cold = 1'b0, sync_in = 1'b0, pd_link = 1'b0, pd_deep = 1'b0;
  logic bclk_en, regs_rst;
  logic [1:0] link_state;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  link_wake_ctrl #(.SYNC_MIN_CYC(MINW), .RESTART_CYC(RC)) u0 (
    .clk(clk), .rst_n_cold(rst_n_cold), .sync_in(sync_in), .pd_link(pd_link),
    .pd_deep(pd_deep), .bclk_en(bclk_en), .regs_rst(regs_rst), .link_state(link_state));

  function automatic bit expect_wake(int width, bit deep);
    return (width >= MINW) && !deep;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cold_reset();
    rst_n_cold = 1'b0;
    #1;
    chk(link_state == 2'd0, "R1 state", link_state, 0);
    chk(regs_rst && !bclk_en, "R1 outputs", {regs_rst, bclk_en}, 2);
    step(2);
    rst_n_cold = 1'b1;
    step();
    chk(link_state == 2'd1, "R2 state", link_state, 1);
    chk(bclk_en && !regs_rst, "R2 outputs", {regs_rst, bclk_en}, 1);
  endtask

  task automatic power_down(bit deep, bit late_deep);
    pd_link = !deep;
    pd_deep = deep;
    step();
    chk(link_state == 2'd2 && !bclk_en, "R3 enter down", link_state, 2);
    pd_link = 1'b0;
    pd_deep = 1'b0;
    if (late_deep) begin
      step(3);
      pd_deep = 1'b1;
      step();
      pd_deep = 1'b0;
      chk(link_state == 2'd2, "R7 late deep", link_state, 2);
    end
  endtask

  task automatic sync_pulse(int w, bit deep);
    bit wake = expect_wake(w, deep);
    bit rst_seen = 1'b0;
    sync_in = 1'b1;
    for (int i = 0; i < w; i++) begin
      step();
      rst_seen |= regs_rst;
    end
    sync_in = 1'b0;
    step(2);
    chk(link_state == 2'd2, "R4 no early wake", link_state, 2);
    step();
    if (wake) begin
      chk(link_state == 2'd3, "R4 wake accepted", link_state, 3);
      for (int k = 1; k < RC; k++) begin
        step();
        rst_seen |= regs_rst;
        chk(link_state == 2'd3 && !bclk_en, "R6 guard held", link_state, 3);
      end
      step();
      chk(link_state == 2'd1 && bclk_en, "R6 back to running", link_state, 1);
      chk(!rst_seen && !regs_rst, "R9 registers kept", rst_seen, 0);
    end else begin
      chk(link_state == 2'd2, deep ? "R7 deep ignores sync" : "R5 short ignored", link_state, 2);
      step(RC + 2);
      chk(link_state == 2'd2 && !regs_rst, "R5 still down", link_state, 2);
    end
  endtask

  task automatic active_noise(int n);
    for (int i = 0; i < n; i++) begin
      sync_in = 1'($urandom_range(0, 1));
      step($urandom_range(1, 4) + ((i % 7 == 0) ? MINW : 0));
    end
    sync_in = 1'b0;
    step(3);
    chk(link_state == 2'd1 && bclk_en, "R8 sync ignored while running", link_state, 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    step();
    cold_reset();
    active_noise(20);
    power_down(1'b0, 1'b0);
    sync_pulse(MINW - 1, 1'b0);
    sync_pulse(MINW, 1'b0);
    power_down(1'b0, 1'b0);
    sync_pulse(3 * MINW, 1'b0);
    power_down(1'b1, 1'b0);
    sync_pulse(MINW + 10, 1'b1);
    sync_pulse(2 * MINW, 1'b1);
    cold_reset();
    power_down(1'b0, 1'b1);
    sync_pulse(MINW + 5, 1'b1);
    cold_reset();
    for (int it = 0; it < 30; it++) begin
      bit deep = ($urandom_range(0, 3) == 0);
      int w = (it % 3 == 0) ? $urandom_range(1, 2 * MINW) : $urandom_range(MINW - 4, MINW + 4);
      power_down(deep, 1'b0);
      sync_pulse(w, deep);
      if (link_state != 2'd1) begin
        if (!deep) begin
          sync_pulse(MINW + 1, 1'b0);
        end else begin
          cold_reset();
        end
      end
      if (it % 5 == 0) active_noise(5);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule